// File: doc/BRIEF.md
# Asynchronous Ring Phase Decoder

This block reads the instantaneous phase of a free-running inverting ring oscillator and reports it as a whole-cycle count plus a fraction of a cycle. The ring's first tap drives two small counters directly. One counter advances on the tap's rising edges and the other on its falling edges. On every rising edge of the sampling clock, the block captures both counts and every tap level. It then passes them through a second flop for metastability settling and decodes the tap pattern into a fractional phase.

A counter is only trustworthy when its clocking edge is far from the sampling instant, so the block takes the whole-cycle value from whichever counter sits in a quiet part of the cycle. When it reads the falling-edge counter, it adds a correction term. The block learns this term on its own whenever the fraction lies in one of two narrow windows. Because of this, the two counters need no common reset and no known startup order.

Top module: `ring_phase_decoder`

## Requirements
- R1: Two 4-bit counters, one advanced by each rising and one by each falling edge of `ring_taps[0]`, count modulo 16 and are cleared by reset.
- R2: `out_valid` is low during reset and rises on the third sampling-clock rising edge after reset is released; a tap pattern held steady appears on the outputs three sampling edges after its first capture.
- R3: The fraction is decoded from a normalized pattern in which bit k is `ring_taps[k]` inverted when k is odd. With `ones` the number of set normalized bits, the code is `ones-1` when `ring_taps[0]` is 1 and `253-ones` otherwise, so every pattern, legal or not, yields a code in 0..253.
- R4: For a fraction code in 63..189 the integer output equals the captured rising-edge count.
- R5: For a fraction code in 190..253 the integer output equals falling count plus correction, modulo 16.
- R6: For a fraction code in 0..62 the integer output equals falling count plus correction plus one, modulo 16.
- R7: A valid sample whose code is in 53..73 loads the correction with rising minus falling minus one; a code in 180..200 loads rising minus falling (modulo 16).
- R8: The correction is zero after reset and keeps its value for every sample whose code lies outside both learning windows.
- R9: Once a learning window has been visited, the integer output follows the rising-edge count through counter wrap-around and with either counter clocked first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all captures on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_taps | input | 127 | Ring stage outputs; bit 0 also clocks both edge counters |
| out_valid | output | 1 | Outputs hold a decoded sample |
| out_int | output | 4 | Whole-cycle phase count |
| out_frac | output | 10 | Fractional phase in 1/254-cycle steps, 0..253 |

## Verification
The bench steps a model ring one stage delay at a time. It lands exactly on the window edges 62/63, 189/190 and 253/0, where picking the wrong counter or omitting the +1 shifts the integer output by one. It reaches a late sample straight from reset, before any learning window, so a correction that does not reset to zero or that loads outside its windows gives a visibly wrong count. Patterns with a flipped bit and an all-zero pattern confirm that a decoder without the odd-stage inversion, or one that searches for a single transition, returns a code other than the ones-count rule. Seventeen full cycles with the falling counter leading since reset show whether counts wrap and the learned offset tracks.

// File: rtl/rpd_pkg.sv
`timescale 1ns/1ps
package rpd_pkg;
  localparam int RPD_NSTAGE     = 127;
  localparam int RPD_CNT_W      = 4;
  localparam int RPD_PHASE_W    = 10;
  localparam int RPD_LEARN_HALF = 10;

  // Which counter is trusted for the current fraction
  typedef enum logic [1:0] {
    ZONE_EARLY = 2'd0,
    ZONE_MID   = 2'd1,
    ZONE_LATE  = 2'd2
  } rpd_zone_e;
endpackage

// File: rtl/rpd_edge_counter.sv
`timescale 1ns/1ps
module rpd_edge_counter #(
  parameter int CNT_W   = rpd_pkg::RPD_CNT_W,
  parameter bit FALLING = 1'b0
) (
  input  logic             rst_n,
  input  logic             tap,
  output logic [CNT_W-1:0] count
);
  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge tap or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
      end
      assert_fall_step_R1: assert property (@(negedge tap) disable iff (!rst_n)
        1'b1 |=> count == $past(count) + 1'b1)
        else $error("falling counter did not advance by one");
    end else begin : g_rise
      always_ff @(posedge tap or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
      end
      assert_rise_step_R1: assert property (@(posedge tap) disable iff (!rst_n)
        1'b1 |=> count == $past(count) + 1'b1)
        else $error("rising counter did not advance by one");
    end
  endgenerate
endmodule

// File: rtl/rpd_sampler.sv
`timescale 1ns/1ps
module rpd_sampler #(
  parameter int NSTAGE = rpd_pkg::RPD_NSTAGE,
  parameter int CNT_W  = rpd_pkg::RPD_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] taps_in,
  input  logic [CNT_W-1:0]  rise_in,
  input  logic [CNT_W-1:0]  fall_in,
  output logic [NSTAGE-1:0] taps_q,
  output logic [CNT_W-1:0]  rise_q,
  output logic [CNT_W-1:0]  fall_q,
  output logic              valid_q
);
  // First stage catches asynchronous levels, second lets them settle
  logic [NSTAGE-1:0] taps_m;
  logic [CNT_W-1:0]  rise_m, fall_m;
  logic              valid_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_m  <= '0;
      rise_m  <= '0;
      fall_m  <= '0;
      valid_m <= 1'b0;
      taps_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      taps_m  <= taps_in;
      rise_m  <= rise_in;
      fall_m  <= fall_in;
      valid_m <= 1'b1;
      taps_q  <= taps_m;
      rise_q  <= rise_m;
      fall_q  <= fall_m;
      valid_q <= valid_m;
    end
  end
endmodule

// File: rtl/rpd_phase_decode.sv
`timescale 1ns/1ps
module rpd_phase_decode #(
  parameter int NSTAGE  = rpd_pkg::RPD_NSTAGE,
  parameter int PHASE_W = rpd_pkg::RPD_PHASE_W
) (
  input  logic [NSTAGE-1:0]  taps,
  output logic [PHASE_W-1:0] frac
);
  localparam int STEPS = 2 * NSTAGE;

  // Undo the inversion of odd stages, then count the set bits
  function automatic int norm_ones(input logic [NSTAGE-1:0] t);
    int n;
    n = 0;
    for (int k = 0; k < NSTAGE; k++) begin
      n += int'(t[k] ^ ((k % 2) == 1));
    end
    return n;
  endfunction

  always_comb begin
    int ones;
    ones = norm_ones(taps);
    if (taps[0]) frac = PHASE_W'(ones - 1);
    else         frac = PHASE_W'(STEPS - 1 - ones);
  end
endmodule

// File: rtl/ring_phase_decoder.sv
`timescale 1ns/1ps
module ring_phase_decoder #(
  parameter int NSTAGE     = rpd_pkg::RPD_NSTAGE,
  parameter int CNT_W      = rpd_pkg::RPD_CNT_W,
  parameter int PHASE_W    = rpd_pkg::RPD_PHASE_W,
  parameter int LEARN_HALF = rpd_pkg::RPD_LEARN_HALF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSTAGE-1:0]  ring_taps,
  output logic               out_valid,
  output logic [CNT_W-1:0]   out_int,
  output logic [PHASE_W-1:0] out_frac
);
  import rpd_pkg::*;

  localparam int STEPS  = 2 * NSTAGE;
  localparam int Q_MID  = STEPS / 4;
  localparam int Q_LATE = Q_MID + NSTAGE;

  logic [CNT_W-1:0]  rise_cnt, fall_cnt;
  logic [NSTAGE-1:0] s_taps;
  logic [CNT_W-1:0]  s_rise, s_fall;
  logic              s_valid;
  logic [PHASE_W-1:0] dec_frac;
  logic [CNT_W-1:0]  corr_q;

  rpd_edge_counter #(.CNT_W(CNT_W), .FALLING(1'b0)) u_rise_cnt (
    .rst_n(rst_n), .tap(ring_taps[0]), .count(rise_cnt));
  rpd_edge_counter #(.CNT_W(CNT_W), .FALLING(1'b1)) u_fall_cnt (
    .rst_n(rst_n), .tap(ring_taps[0]), .count(fall_cnt));

  rpd_sampler #(.NSTAGE(NSTAGE), .CNT_W(CNT_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .taps_in(ring_taps),
    .rise_in(rise_cnt), .fall_in(fall_cnt),
    .taps_q(s_taps), .rise_q(s_rise), .fall_q(s_fall), .valid_q(s_valid));

  rpd_phase_decode #(.NSTAGE(NSTAGE), .PHASE_W(PHASE_W)) u_decode (
    .taps(s_taps), .frac(dec_frac));

  function automatic rpd_zone_e zone_of(input logic [PHASE_W-1:0] f);
    if (f >= PHASE_W'(Q_LATE))     return ZONE_LATE;
    else if (f >= PHASE_W'(Q_MID)) return ZONE_MID;
    else                           return ZONE_EARLY;
  endfunction

  function automatic logic in_window(input logic [PHASE_W-1:0] f, input int ctr);
    return (f >= PHASE_W'(ctr - LEARN_HALF)) && (f <= PHASE_W'(ctr + LEARN_HALF));
  endfunction

  function automatic logic [CNT_W-1:0] pick_int(input rpd_zone_e z,
      input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] fl, input logic [CNT_W-1:0] c);
    case (z)
      ZONE_MID:  return r;
      ZONE_LATE: return fl + c;
      default:   return fl + c + 1'b1;
    endcase
  endfunction

  // Named events for the checks below
  rpd_zone_e        zone;
  logic             learn_early, learn_late;
  logic [CNT_W-1:0] int_next, corr_next;

  always_comb begin
    zone        = zone_of(dec_frac);
    learn_early = in_window(dec_frac, Q_MID);
    learn_late  = in_window(dec_frac, Q_LATE);
    int_next    = pick_int(zone, s_rise, s_fall, corr_q);
    if (learn_early)     corr_next = s_rise - s_fall - 1'b1;
    else if (learn_late) corr_next = s_rise - s_fall;
    else                 corr_next = corr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q    <= '0;
      out_valid <= 1'b0;
      out_int   <= '0;
      out_frac  <= '0;
    end else begin
      out_valid <= s_valid;
      out_int   <= int_next;
      out_frac  <= dec_frac;
      if (s_valid) corr_q <= corr_next;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s_valid))
    else $error("valid without a settled sample");

  assert_frac_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_frac < PHASE_W'(STEPS))
    else $error("fraction code out of range");

  assert_mid_uses_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && zone == ZONE_MID) |=> out_int == $past(s_rise))
    else $error("mid zone did not take rising count");

  assert_late_uses_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && zone == ZONE_LATE) |=> out_int == $past(s_fall + corr_q))
    else $error("late zone integer mismatch");

  assert_learn_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && learn_late) |=> corr_q == $past(s_rise - s_fall))
    else $error("late window did not load correction");

  assert_corr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !learn_early && !learn_late) |=> corr_q == $past(corr_q))
    else $error("correction changed outside windows");
endmodule

// File: tb/ring_phase_decoder_bench.sv
`timescale 1ns/1ps
module ring_phase_decoder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [126:0] taps;
  logic         out_valid;
  logic [3:0]   out_int;
  logic [9:0]   out_frac;

  ring_phase_decoder u_ring_phase_decoder (
    .clk(clk), .rst_n(rst_n), .ring_taps(taps),
    .out_valid(out_valid), .out_int(out_int), .out_frac(out_frac));

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int p = 0;
  logic [3:0] brise = 4'd0, bfall = 4'd0, bcorr = 4'd0;
  logic done = 1'b0;

  // Ring advances: steps per table entry
  localparam int N_VEC = 12;
  localparam int ADV [N_VEC] = '{84, 40, 100, 40, 30, 200, 100, 1, 126, 1, 63, 1};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Ideal level of each tap at phase q, odd stages inverted
  function automatic logic [126:0] ring_word(input int q);
    logic [126:0] w;
    for (int k = 0; k < 127; k++) begin
      w[k] = (((((q - k) % 254) + 254) % 254) < 127) ^ ((k % 2) == 1);
    end
    return w;
  endfunction

  function automatic int frac_of(input logic [126:0] w);
    int ones;
    ones = 0;
    for (int k = 0; k < 127; k++) ones += int'(w[k] != ((k % 2) == 1));
    return w[0] ? ones - 1 : 253 - ones;
  endfunction

  task automatic apply(input logic [126:0] w);
    if (rst_n) begin
      if (!taps[0] && w[0]) brise = brise + 4'd1;
      if (taps[0] && !w[0]) bfall = bfall + 4'd1;
    end
    taps = w;
    #0.01;
  endtask

  task automatic walk(input int steps);
    @(negedge clk);
    for (int i = 0; i < steps; i++) begin
      p = (p + 1) % 254;
      apply(ring_word(p));
    end
  endtask

  task automatic walk_to(input int target);
    walk(((target - p) % 254 + 254) % 254);
  endtask

  task automatic hold_check(input string tag, input int f);
    logic [3:0] e;
    repeat (6) @(posedge clk);
    #2;
    if (f >= 53 && f <= 73)        bcorr = brise - bfall - 4'd1;  // R7
    else if (f >= 180 && f <= 200) bcorr = brise - bfall;         // R7
    if (f >= 63 && f <= 189) e = brise;                           // R4
    else if (f >= 190)       e = bfall + bcorr;                   // R5
    else                     e = bfall + bcorr + 4'd1;            // R6
    check({tag, " R3 frac"}, int'(out_frac), f);
    check({tag, " R4/R5/R6 int"}, int'(out_int), int'(e));
    check({tag, " R2 valid"}, int'(out_valid), 1);
  endtask

  initial begin
    taps = ring_word(0);
    repeat (3) @(posedge clk);
    #2;
    check("R2 valid in reset", int'(out_valid), 0);
    check("R1 int in reset", int'(out_int), 0);
    check("R3 frac in reset", int'(out_frac), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 check("R2 valid edge1", int'(out_valid), 0);
    @(posedge clk); #2 check("R2 valid edge2", int'(out_valid), 0);
    @(posedge clk); #2 check("R2 valid edge3", int'(out_valid), 1);

    // R8: late sample before any learning uses a zero correction
    walk_to(230);
    hold_check("R8 unlearned", 230);
    check("R8 zero corr gives fall count", int'(out_int), 1);

    for (int v = 0; v < N_VEC; v++) begin
      walk(ADV[v]);
      hold_check($sformatf("vec%0d", v), p);
    end

    // R3: flipped bit and all-zero pattern follow the ones-count rule
    walk_to(230);
    begin
      logic [126:0] bw;
      bw = ring_word(230) ^ (127'd1 << 100);
      @(negedge clk) apply(bw);
      hold_check("R3 bubble", frac_of(bw));
      @(negedge clk) apply('0);
      hold_check("R3 all-zero", 190);
      @(negedge clk) apply(ring_word(230));
      hold_check("R3 restore", 230);
    end

    // R9: many full cycles, counters wrap, integer tracks rising count
    walk_to(60);
    for (int c = 0; c < 17; c++) begin
      walk(254);
      hold_check($sformatf("wrap%0d", c), 60);
      check("R9 int tracks rise", int'(out_int), int'(brise));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule